// File: doc/BRIEF.md
# Repeated String Operation Engine

This block executes block string operations against a byte-wide memory port. One start pulse launches a move, compare, scan, load or store of byte or word elements, optionally repeated under a count register and, for compare and scan, under a zero-flag condition. At start it captures the source and destination indices, the element count, the accumulator, two segment bases, the direction flag and the operation selects. It then steps through the elements one byte access per cycle and reports the final register values and comparison flags at its outputs.

Each address is a segment base shifted left by four bits plus a 16-bit index, giving a 20-bit byte address. A word element is two byte accesses, low byte first, at index and index+1. After each element the indices that the operation touches move by the element size, up or down according to the direction flag. A `done` pulse marks the end of the whole operation.

Top module: `strop_engine`

## Requirements
- R1: After reset the index, count and accumulator outputs and the three flags are 0, and `busy` and `done` are low.
- R2: The source byte address is `ds_seg`*16 + SI and the destination byte address is `es_seg`*16 + DI, modulo 2^20; for a word element the low byte is at the index and the high byte at index+1.
- R3: After each element, every index the operation uses moves by 1 for bytes or 2 for words (`word_sel`=1): up when `dir_flag`=0, down when `dir_flag`=1. Move and compare step SI and DI, scan and store step only DI, load steps only SI.
- R4: Move (`op_sel`=0) copies the source element to the destination element.
- R5: Load (`op_sel`=3) puts the source element in the accumulator; a byte load replaces only bits 7:0 and keeps bits 15:8. Store (`op_sel`=4) writes accumulator bits 7:0 (byte) or 15:0 (word) to the destination.
- R6: Compare (`op_sel`=1) evaluates source minus destination and scan (`op_sel`=2) evaluates accumulator minus destination, unsigned over the element size, setting CF=1,ZF=0,SF=1 when less, CF=0,ZF=1,SF=0 when equal, all 0 when greater. No other operation changes the flags.
- R7: With a repeat mode (`rep_sel`=1, 2 or 3) the count is tested before each element: a count of 0 at start processes nothing and leaves every register unchanged; otherwise the count drops by 1 after each element and the run ends when it reaches 0.
- R8: For compare and scan, `rep_sel`=2 also ends the run after an element that leaves ZF=0, and `rep_sel`=3 after one that leaves ZF=1. For move, load and store, modes 2 and 3 behave as mode 1.
- R9: With `rep_sel`=0 exactly one element is processed and the count is unchanged.
- R10: `done` is high for exactly one cycle when an operation ends, and never while `busy` is high; `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch pulse, taken when idle |
| op_sel | input | 3 | 0 move, 1 compare, 2 scan, 3 load, 4 store |
| word_sel | input | 1 | 1 word elements, 0 byte elements |
| rep_sel | input | 2 | 0 single, 1 repeat, 2 repeat while equal, 3 repeat while not equal |
| dir_flag | input | 1 | 0 indices rise, 1 indices fall |
| ds_seg | input | 16 | Source segment base |
| es_seg | input | 16 | Destination segment base |
| si_init | input | 16 | Starting source index |
| di_init | input | 16 | Starting destination index |
| cx_init | input | 16 | Starting element count |
| acc_init | input | 16 | Starting accumulator |
| mem_addr | output | 20 | Byte address of the current access |
| mem_we | output | 1 | Write strobe for the current access |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte for `mem_addr`, same cycle |
| si_out | output | 16 | Source index |
| di_out | output | 16 | Destination index |
| cx_out | output | 16 | Element count |
| acc_out | output | 16 | Accumulator |
| cf | output | 1 | Carry flag |
| zf | output | 1 | Zero flag |
| sf | output | 1 | Sign flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end pulse |

## Verification
A wrong byte counter or address offset writes or reads the wrong bytes, so it shows as a corrupted destination region or a wrong accumulator in the same `done` cycle that ends the operation. A wrong termination decision leaves the count and both indices off by one or more elements at `done`, and a flag computed from stale operand bytes shows as a wrong CF/ZF/SF triple there too. Stray writes outside the intended region are caught by comparing the whole memory image once the operation ends.

// File: rtl/strop_pkg.sv
package strop_pkg;

   typedef enum logic [2:0] {
      OP_MOVE  = 3'd0,
      OP_CMP   = 3'd1,
      OP_SCAN  = 3'd2,
      OP_LOAD  = 3'd3,
      OP_STORE = 3'd4
   } strop_op_e;

   typedef enum logic [1:0] {
      RP_NONE     = 2'd0,
      RP_ALL      = 2'd1,
      RP_WHILE_EQ = 2'd2,
      RP_WHILE_NE = 2'd3
   } strop_rep_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SRC,
      ST_DST,
      ST_FIN
   } strop_state_e;

   // operations that fetch a source element
   function automatic logic reads_src(strop_op_e o);
      return (o == OP_MOVE) || (o == OP_CMP) || (o == OP_LOAD);
   endfunction

   // operations that touch the destination element
   function automatic logic uses_dst(strop_op_e o);
      return (o != OP_LOAD);
   endfunction

   function automatic logic writes_dst(strop_op_e o);
      return (o == OP_MOVE) || (o == OP_STORE);
   endfunction

   function automatic logic sets_flags(strop_op_e o);
      return (o == OP_CMP) || (o == OP_SCAN);
   endfunction

endpackage

// File: rtl/strop_agu.sv
module strop_agu #(
   parameter int IDX_W     = 16,
   parameter int SEG_W     = 16,
   parameter int SEG_SHIFT = 4,
   parameter int ADDR_W    = 20,
   parameter int OFF_W     = 1
) (
   input  logic [SEG_W-1:0]  seg,
   input  logic [IDX_W-1:0]  idx,
   input  logic [OFF_W-1:0]  off,
   output logic [ADDR_W-1:0] addr
);
   localparam int BASE_W = SEG_W + SEG_SHIFT;

   logic [IDX_W-1:0]  eff;
   logic [BASE_W-1:0] base;

   // byte offset inside the element wraps within the index width
   assign eff  = idx + IDX_W'(off);
   assign base = {seg, {SEG_SHIFT{1'b0}}};
   assign addr = ADDR_W'(base) + ADDR_W'(eff);
endmodule

// File: rtl/strop_step.sv
module strop_step #(
   parameter int IDX_W      = 16,
   parameter int WORD_BYTES = 2
) (
   input  logic [IDX_W-1:0] idx,
   input  logic             dir,
   input  logic             word,
   input  logic             en,
   output logic [IDX_W-1:0] nxt
);
   logic [IDX_W-1:0] step;

   assign step = word ? IDX_W'(WORD_BYTES) : IDX_W'(1);

   always_comb begin
      if (!en)
         nxt = idx;
      else if (dir)
         nxt = idx - step;
      else
         nxt = idx + step;
   end
endmodule

// File: rtl/strop_cmp.sv
module strop_cmp #(
   parameter int BYTE_W     = 8,
   parameter int WORD_BYTES = 2,
   localparam int ACC_W     = BYTE_W * WORD_BYTES
) (
   input  logic [ACC_W-1:0] a,
   input  logic [ACC_W-1:0] b,
   input  logic             word,
   output logic             cf,
   output logic             zf,
   output logic             sf
);
   logic [ACC_W-1:0] am, bm;
   logic             below;

   // byte elements compare only their low byte
   assign am    = word ? a : {{(ACC_W-BYTE_W){1'b0}}, a[BYTE_W-1:0]};
   assign bm    = word ? b : {{(ACC_W-BYTE_W){1'b0}}, b[BYTE_W-1:0]};
   assign below = (am < bm);
   assign zf    = (am == bm);
   assign cf    = below;
   assign sf    = below;
endmodule

// File: rtl/strop_engine.sv
module strop_engine
   import strop_pkg::*;
#(
   parameter int BYTE_W     = 8,
   parameter int WORD_BYTES = 2,
   parameter int IDX_W      = 16,
   parameter int SEG_W      = 16,
   parameter int SEG_SHIFT  = 4,
   parameter int ADDR_W     = 20,
   localparam int ACC_W     = BYTE_W * WORD_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        op_sel,
   input  logic              word_sel,
   input  logic [1:0]        rep_sel,
   input  logic              dir_flag,
   input  logic [SEG_W-1:0]  ds_seg,
   input  logic [SEG_W-1:0]  es_seg,
   input  logic [IDX_W-1:0]  si_init,
   input  logic [IDX_W-1:0]  di_init,
   input  logic [IDX_W-1:0]  cx_init,
   input  logic [ACC_W-1:0]  acc_init,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic [BYTE_W-1:0] mem_wdata,
   input  logic [BYTE_W-1:0] mem_rdata,
   output logic [IDX_W-1:0]  si_out,
   output logic [IDX_W-1:0]  di_out,
   output logic [IDX_W-1:0]  cx_out,
   output logic [ACC_W-1:0]  acc_out,
   output logic              cf,
   output logic              zf,
   output logic              sf,
   output logic              busy,
   output logic              done
);
   localparam int KW = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;
   localparam int NPTR = 2;   // 0 = source side, 1 = destination side

   if (WORD_BYTES < 2) begin : g_bad_word
      $error("strop_engine: WORD_BYTES must be at least 2");
   end
   if (ADDR_W < IDX_W) begin : g_bad_addr
      $error("strop_engine: ADDR_W must not be narrower than IDX_W");
   end
   if (IDX_W < KW + 1) begin : g_bad_idx
      $error("strop_engine: IDX_W too narrow for the word step");
   end

   strop_state_e     state_q;
   strop_op_e        op_q;
   strop_rep_e       rep_q;
   logic             word_q, dir_q;
   logic [SEG_W-1:0] seg_q [NPTR];
   logic [IDX_W-1:0] idx_q [NPTR];
   logic [IDX_W-1:0] idx_nxt [NPTR];
   logic [ADDR_W-1:0] addr_w [NPTR];
   logic [NPTR-1:0]  step_en;
   logic [IDX_W-1:0] cx_q, cx_dec;
   logic [ACC_W-1:0] acc_q, sbuf_q, dbuf_q, cmp_a;
   logic [KW-1:0]    k_q, last_k;
   logic             cf_q, zf_q, sf_q, done_q;
   logic             cmp_cf, cmp_zf, cmp_sf, more;
   strop_op_e        op_in;

   assign op_in      = strop_op_e'(op_sel);
   assign last_k     = word_q ? KW'(WORD_BYTES - 1) : '0;
   assign step_en[0] = reads_src(op_q);
   assign step_en[1] = uses_dst(op_q);
   assign cx_dec     = cx_q - IDX_W'(1);

   for (genvar g = 0; g < NPTR; g++) begin : g_ptr
      strop_agu #(
         .IDX_W(IDX_W), .SEG_W(SEG_W), .SEG_SHIFT(SEG_SHIFT),
         .ADDR_W(ADDR_W), .OFF_W(KW)
      ) u_agu (
         .seg(seg_q[g]), .idx(idx_q[g]), .off(k_q), .addr(addr_w[g])
      );
      strop_step #(.IDX_W(IDX_W), .WORD_BYTES(WORD_BYTES)) u_step (
         .idx(idx_q[g]), .dir(dir_q), .word(word_q),
         .en(step_en[g]), .nxt(idx_nxt[g])
      );
   end

   assign cmp_a = (op_q == OP_SCAN) ? acc_q : sbuf_q;

   strop_cmp #(.BYTE_W(BYTE_W), .WORD_BYTES(WORD_BYTES)) u_cmp (
      .a(cmp_a), .b(dbuf_q), .word(word_q),
      .cf(cmp_cf), .zf(cmp_zf), .sf(cmp_sf)
   );

   // continue decision taken at the end of each element
   always_comb begin
      more = 1'b0;
      if (rep_q != RP_NONE && cx_dec != '0) begin
         more = 1'b1;
         if (sets_flags(op_q)) begin
            if (rep_q == RP_WHILE_EQ && !cmp_zf) more = 1'b0;
            if (rep_q == RP_WHILE_NE &&  cmp_zf) more = 1'b0;
         end
      end
   end

   assign mem_addr  = (state_q == ST_SRC) ? addr_w[0] : addr_w[1];
   assign mem_we    = (state_q == ST_DST) && writes_dst(op_q);
   assign mem_wdata = (op_q == OP_MOVE) ? sbuf_q[int'(k_q)*BYTE_W +: BYTE_W]
                                        : acc_q[int'(k_q)*BYTE_W +: BYTE_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         op_q     <= OP_MOVE;
         rep_q    <= RP_NONE;
         word_q   <= 1'b0;
         dir_q    <= 1'b0;
         seg_q[0] <= '0;
         seg_q[1] <= '0;
         idx_q[0] <= '0;
         idx_q[1] <= '0;
         cx_q     <= '0;
         acc_q    <= '0;
         sbuf_q   <= '0;
         dbuf_q   <= '0;
         k_q      <= '0;
         cf_q     <= 1'b0;
         zf_q     <= 1'b0;
         sf_q     <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  op_q     <= op_in;
                  rep_q    <= strop_rep_e'(rep_sel);
                  word_q   <= word_sel;
                  dir_q    <= dir_flag;
                  seg_q[0] <= ds_seg;
                  seg_q[1] <= es_seg;
                  idx_q[0] <= si_init;
                  idx_q[1] <= di_init;
                  cx_q     <= cx_init;
                  acc_q    <= acc_init;
                  k_q      <= '0;
                  if (rep_sel != 2'(RP_NONE) && cx_init == '0)
                     done_q <= 1'b1;
                  else
                     state_q <= reads_src(op_in) ? ST_SRC : ST_DST;
               end
            end
            ST_SRC: begin
               sbuf_q[int'(k_q)*BYTE_W +: BYTE_W] <= mem_rdata;
               if (k_q == last_k) begin
                  k_q     <= '0;
                  state_q <= uses_dst(op_q) ? ST_DST : ST_FIN;
               end else begin
                  k_q <= k_q + KW'(1);
               end
            end
            ST_DST: begin
               if (!writes_dst(op_q))
                  dbuf_q[int'(k_q)*BYTE_W +: BYTE_W] <= mem_rdata;
               if (k_q == last_k) begin
                  k_q     <= '0;
                  state_q <= ST_FIN;
               end else begin
                  k_q <= k_q + KW'(1);
               end
            end
            ST_FIN: begin
               idx_q[0] <= idx_nxt[0];
               idx_q[1] <= idx_nxt[1];
               if (op_q == OP_LOAD) begin
                  if (word_q)
                     acc_q <= sbuf_q;
                  else
                     acc_q[BYTE_W-1:0] <= sbuf_q[BYTE_W-1:0];
               end
               if (sets_flags(op_q)) begin
                  cf_q <= cmp_cf;
                  zf_q <= cmp_zf;
                  sf_q <= cmp_sf;
               end
               if (rep_q != RP_NONE)
                  cx_q <= cx_dec;
               if (more) begin
                  state_q <= reads_src(op_q) ? ST_SRC : ST_DST;
               end else begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign si_out  = idx_q[0];
   assign di_out  = idx_q[1];
   assign cx_out  = cx_q;
   assign acc_out = acc_q;
   assign cf      = cf_q;
   assign zf      = zf_q;
   assign sf      = sf_q;
   assign busy    = (state_q != ST_IDLE);
   assign done    = done_q;
endmodule

// File: rtl/strop_engine_chk.sv
module strop_engine_chk #(
   parameter int IDX_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             done,
   input logic             mem_we,
   input logic [IDX_W-1:0] cx_out,
   input logic [IDX_W-1:0] si_out,
   input logic [IDX_W-1:0] di_out,
   input logic             cf,
   input logic             zf,
   input logic             sf
);
   localparam logic [IDX_W-1:0] ONE = IDX_W'(1);
   localparam logic [IDX_W-1:0] TWO = IDX_W'(2);

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);  // R10

   AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);  // R10

   AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> busy);  // R4

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> (cx_out == $past(cx_out) || cx_out == $past(cx_out) - ONE));  // R7

   AST_FLAG_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      !(zf && cf) && (cf == sf));  // R6

   AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(busy)) |-> $stable({cf, zf, sf}));  // R6

   AST_SI_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && si_out != $past(si_out)) |->
         (si_out == $past(si_out) + ONE || si_out == $past(si_out) + TWO ||
          si_out == $past(si_out) - ONE || si_out == $past(si_out) - TWO));  // R3

   AST_DI_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && di_out != $past(di_out)) |->
         (di_out == $past(di_out) + ONE || di_out == $past(di_out) + TWO ||
          di_out == $past(di_out) - ONE || di_out == $past(di_out) - TWO));  // R3
endmodule

bind strop_engine strop_engine_chk #(.IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mem_we(mem_we),
   .cx_out(cx_out), .si_out(si_out), .di_out(di_out),
   .cf(cf), .zf(zf), .sf(sf)
);

// File: tb/tb_strop_engine.sv
module tb_strop_engine;
   localparam int CLK_PERIOD = 10;
   localparam int MEM_N      = 4096;

   localparam int OPM = 0, OPC = 1, OPS = 2, OPL = 3, OPT = 4;

   typedef struct {
      logic [15:0] si, di, cx, acc;
      logic        cf, zf, sf;
      string       tag;
   } exp_t;

   logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [2:0]  op_sel = '0;
   logic        word_sel = 1'b0, dir_flag = 1'b0;
   logic [1:0]  rep_sel = '0;
   logic [15:0] ds_seg = '0, es_seg = '0, si_init = '0, di_init = '0, cx_init = '0, acc_init = '0;
   logic [19:0] mem_addr;
   logic        mem_we;
   logic [7:0]  mem_wdata, mem_rdata;
   logic [15:0] si_out, di_out, cx_out, acc_out;
   logic        cf, zf, sf, busy, done;

   logic [7:0] mem     [MEM_N];
   logic [7:0] ref_mem [MEM_N];
   exp_t       sb [$];
   int         total = 0, bad = 0;
   logic       m_cf = 1'b0, m_zf = 1'b0, m_sf = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   strop_engine dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .word_sel(word_sel),
      .rep_sel(rep_sel), .dir_flag(dir_flag), .ds_seg(ds_seg), .es_seg(es_seg),
      .si_init(si_init), .di_init(di_init), .cx_init(cx_init), .acc_init(acc_init),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .si_out(si_out), .di_out(di_out), .cx_out(cx_out), .acc_out(acc_out),
      .cf(cf), .zf(zf), .sf(sf), .busy(busy), .done(done)
   );

   assign mem_rdata = mem[mem_addr[11:0]];
   always @(posedge clk) if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;

   task automatic check(input bit ok, input string req, input string act, input string exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%s expected=%s", req, act, exp);
      end
   endtask

   function automatic int ad(input logic [15:0] seg, input logic [15:0] idx, input int k);
      logic [15:0] e;
      logic [19:0] f;
      e = idx + 16'(k);
      f = {seg, 4'h0} + {4'h0, e};
      return int'(f[11:0]);
   endfunction

   task automatic poke(input int a, input logic [7:0] v);
      mem[a] = v;
      ref_mem[a] = v;
   endtask

   // requirement-level model; updates ref_mem and model flags, pushes expected registers
   task automatic model(input int op, input bit wd, input int rep, input bit dr,
                        input logic [15:0] ds, input logic [15:0] es, input logic [15:0] si0,
                        input logic [15:0] di0, input logic [15:0] cx0, input logic [15:0] acc0,
                        input string tag);
      exp_t e;
      logic [15:0] si, di, cx, acc, a, b, x;
      int n, st;
      bit go;
      si = si0; di = di0; cx = cx0; acc = acc0;
      n  = wd ? 2 : 1;
      st = wd ? 2 : 1;
      go = !(rep != 0 && cx == 16'h0);
      while (go) begin
         a = '0; b = '0;
         for (int k = 0; k < n; k++)
            if (op == OPM || op == OPC || op == OPL) a[k*8 +: 8] = ref_mem[ad(ds, si, k)];
         for (int k = 0; k < n; k++) begin
            if (op == OPM) ref_mem[ad(es, di, k)] = a[k*8 +: 8];
            else if (op == OPT) ref_mem[ad(es, di, k)] = acc[k*8 +: 8];
            else if (op == OPC || op == OPS) b[k*8 +: 8] = ref_mem[ad(es, di, k)];
         end
         if (op == OPL) begin
            if (wd) acc = a; else acc[7:0] = a[7:0];
         end
         if (op == OPC || op == OPS) begin
            x = (op == OPS) ? (wd ? acc : {8'h00, acc[7:0]}) : a;
            m_zf = (x == b);
            m_cf = (x < b);
            m_sf = m_cf;
         end
         if (op == OPM || op == OPC || op == OPL) si = dr ? si - 16'(st) : si + 16'(st);
         if (op != OPL) di = dr ? di - 16'(st) : di + 16'(st);
         if (rep == 0) go = 0;
         else begin
            cx = cx - 16'h1;
            if (cx == 16'h0) go = 0;
            else if ((op == OPC || op == OPS) && ((rep == 2 && !m_zf) || (rep == 3 && m_zf))) go = 0;
         end
      end
      e.si = si; e.di = di; e.cx = cx; e.acc = acc;
      e.cf = m_cf; e.zf = m_zf; e.sf = m_sf; e.tag = tag;
      sb.push_back(e);
   endtask

   // driver: computes expectation, launches, waits for end, checks memory image
   task automatic run_op(input int op, input bit wd, input int rep, input bit dr,
                         input logic [15:0] ds, input logic [15:0] es, input logic [15:0] si0,
                         input logic [15:0] di0, input logic [15:0] cx0, input logic [15:0] acc0,
                         input bit glitch, input string tag);
      int diffs;
      model(op, wd, rep, dr, ds, es, si0, di0, cx0, acc0, tag);
      @(negedge clk);
      op_sel = 3'(op); word_sel = wd; rep_sel = 2'(rep); dir_flag = dr;
      ds_seg = ds; es_seg = es; si_init = si0; di_init = di0; cx_init = cx0; acc_init = acc0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (glitch) begin
         repeat (3) @(negedge clk);
         op_sel = 3'(OPT); acc_init = 16'hDEAD; cx_init = 16'h0001;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (!done) @(negedge clk);
      @(negedge clk);
      diffs = 0;
      for (int i = 0; i < MEM_N; i++) if (mem[i] !== ref_mem[i]) diffs++;
      check(diffs == 0, {tag, " memory"}, $sformatf("%0d bytes differ", diffs), "0 bytes differ");
   endtask

   // monitor: pops the scoreboard on each done pulse
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (sb.size() == 0) begin
            check(1'b0, "R10 unexpected done", "done", "no done");
         end else begin
            exp_t e;
            e = sb.pop_front();
            check({si_out, di_out, cx_out, acc_out, cf, zf, sf} ===
                  {e.si, e.di, e.cx, e.acc, e.cf, e.zf, e.sf}, e.tag,
                  $sformatf("si=%h di=%h cx=%h acc=%h f=%b%b%b", si_out, di_out, cx_out, acc_out, cf, zf, sf),
                  $sformatf("si=%h di=%h cx=%h acc=%h f=%b%b%b", e.si, e.di, e.cx, e.acc, e.cf, e.zf, e.sf));
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < MEM_N; i++) begin
         mem[i] = 8'(i * 7 + 3);
         ref_mem[i] = 8'(i * 7 + 3);
      end
      repeat (3) @(negedge clk);
      // R1 reset state
      check({si_out, di_out, cx_out, acc_out, cf, zf, sf, busy, done} === '0, "R1 reset",
            $sformatf("%h %h %h %h %b%b%b %b %b", si_out, di_out, cx_out, acc_out, cf, zf, sf, busy, done), "all zero");
      rst_n = 1'b1;
      @(negedge clk);

      // R4 R3 R7 R2 byte move upward
      run_op(OPM, 0, 1, 0, 16'h0010, 16'h0040, 16'h0020, 16'h0030, 16'd4, 16'h0, 0, "R4 R3 R7 R2 byte move");
      // R4 R3 word move downward
      run_op(OPM, 1, 1, 1, 16'h0010, 16'h0040, 16'h0060, 16'h0080, 16'd3, 16'h0, 0, "R4 R3 word move down");
      // R5 R9 R2 single word store at 0x500+0x123
      run_op(OPT, 1, 0, 0, 16'h0000, 16'h0050, 16'h0007, 16'h0123, 16'd5, 16'hBEEF, 0, "R5 R9 R2 word store");
      check({mem[12'h623], mem[12'h624]} === 16'hEFBE, "R2 store bytes",
            $sformatf("%h%h", mem[12'h623], mem[12'h624]), "efbe");
      // R5 R3 repeated byte store downward
      run_op(OPT, 0, 1, 1, 16'h0010, 16'h0040, 16'h0005, 16'h0040, 16'd3, 16'h1234, 0, "R5 R3 byte store down");
      // R5 R9 word load
      run_op(OPL, 1, 0, 0, 16'h0010, 16'h0040, 16'h0010, 16'h0009, 16'd2, 16'h0000, 0, "R5 R9 word load");
      // R5 byte load keeps high byte
      run_op(OPL, 0, 0, 1, 16'h0010, 16'h0040, 16'h0011, 16'h0009, 16'd2, 16'hAA55, 0, "R5 byte load");

      // R8 R6 compare while equal: three matches then source smaller
      for (int k = 0; k < 8; k++) begin
         poke(ad(16'h0010, 16'h0100, k), 8'(8'h40 + k));
         poke(ad(16'h0040, 16'h0100, k), 8'(8'h40 + k + ((k >= 3) ? 1 : 0)));
      end
      run_op(OPC, 0, 2, 0, 16'h0010, 16'h0040, 16'h0100, 16'h0100, 16'd8, 16'h0, 0, "R8 R6 compare while equal");
      // R8 R6 scan while not equal: match at fifth byte
      for (int k = 0; k < 10; k++) poke(ad(16'h0040, 16'h0180, k), (k == 4) ? 8'h5A : 8'(8'h10 + k));
      run_op(OPS, 0, 3, 0, 16'h0010, 16'h0040, 16'h0000, 16'h0180, 16'd10, 16'h775A, 0, "R8 R6 scan while not equal");
      // R6 R9 single word scan, accumulator greater
      poke(ad(16'h0040, 16'h01C0, 0), 8'h00); poke(ad(16'h0040, 16'h01C0, 1), 8'h12);
      run_op(OPS, 1, 0, 0, 16'h0010, 16'h0040, 16'h0000, 16'h01C0, 16'd9, 16'h3400, 0, "R6 R9 scan greater");
      // R6 R3 single word compare, equal, downward
      poke(ad(16'h0010, 16'h01D0, 0), 8'h11); poke(ad(16'h0010, 16'h01D0, 1), 8'h22);
      poke(ad(16'h0040, 16'h01E0, 0), 8'h11); poke(ad(16'h0040, 16'h01E0, 1), 8'h22);
      run_op(OPC, 1, 0, 1, 16'h0010, 16'h0040, 16'h01D0, 16'h01E0, 16'd1, 16'h0, 0, "R6 R3 compare equal");
      // R6 move leaves flags, R7 zero count does nothing
      run_op(OPM, 0, 1, 0, 16'h0010, 16'h0040, 16'h0020, 16'h0030, 16'd0, 16'h4321, 0, "R7 zero count");
      // R8 move ignores zero-flag modes
      run_op(OPM, 0, 3, 0, 16'h0010, 16'h0040, 16'h0140, 16'h0150, 16'd3, 16'h0, 0, "R8 move with while-not-equal");
      // R7 R6 plain repeat compare runs the full count
      run_op(OPC, 0, 1, 0, 16'h0010, 16'h0040, 16'h0100, 16'h0100, 16'd6, 16'h0, 0, "R7 R6 plain repeat compare");
      // R10 start while busy is ignored
      run_op(OPM, 1, 1, 0, 16'h0010, 16'h0040, 16'h0000, 16'h0200, 16'd4, 16'h0, 1, "R10 start while busy");

      check(sb.size() == 0, "R10 done count", $sformatf("%0d pending", sb.size()), "0 pending");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule